// File: doc/BRIEF.md
# Load/Store Lane Alignment Unit

This unit sits between a 64-bit integer core and a 64-bit little-endian data memory port. It handles the byte-lane work around a memory access. On the access side it forms the effective address from a base register value and a signed 12-bit offset. From that address it derives the doubleword-aligned line address, the per-lane write strobes and the write data with the source bytes replicated into every lane group. It also raises a flag when the access is not naturally aligned.

On the return side it takes the raw 64-bit word read from memory, together with the low three address bits, the access size and a signedness flag. It moves the addressed lanes down to bit 0 and extends them to the full 64 bits.

Both paths pass through one register stage. Every output therefore reflects the inputs sampled at the previous rising clock edge. Memory, caches, trapping and atomics lie outside this unit. The misalignment flag is reported to the surrounding logic and does nothing else.

Size codes on both paths are 0 = byte (1 byte), 1 = half (2 bytes), 2 = word (4 bytes) and 3 = double (8 bytes).

Top module: `mem_lane_align`

## Requirements
- R1: `eff_addr` equals `acc_base` plus `acc_offset` sign-extended from 12 bits, taken modulo 2^64. It appears one cycle after the inputs are sampled.
- R2: `line_addr` equals the effective address with bits [2:0] forced to zero.
- R3: `misaligned` is 1 exactly when the effective address bits [2:0] are not a multiple of the access byte count (1, 2, 4 or 8). While it is 1, `byte_en` is all zeros.
- R4: For an aligned access, `byte_en` bit i (lane i holds address byte i, little-endian) is 1 exactly for the 1, 2, 4 or 8 consecutive lanes that start at the effective address bits [2:0].
- R5: `wr_data` lane i carries source byte (i mod n) of `acc_wdata`, where n is the access byte count. Source bytes at or above n have no effect on `wr_data`.
- R6: The return path shifts `ld_word` right by 8 × `ld_lane` bits before it takes the low n bytes. Lanes beyond lane 7 read as zero.
- R7: With `ld_unsigned` = 0, byte, half and word results are sign-extended from bit 7, 15 or 31 of the selected data.
- R8: With `ld_unsigned` = 1, byte, half and word results are zero-extended.
- R9: A double return with `ld_lane` = 0 gives `ld_word` unchanged, whatever the value of `ld_unsigned`.
- R10: While `rst` is high at a rising edge, every output is zero in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| acc_base | input | 64 | Base register value |
| acc_offset | input | 12 | Signed immediate offset |
| acc_size | input | 2 | Access size code |
| acc_wdata | input | 64 | Store source register value |
| eff_addr | output | 64 | Registered effective address |
| line_addr | output | 64 | Registered doubleword-aligned address |
| byte_en | output | 8 | Registered per-lane write strobes |
| wr_data | output | 64 | Registered replicated write data |
| misaligned | output | 1 | Registered natural-alignment violation flag |
| ld_word | input | 64 | Raw memory word |
| ld_lane | input | 3 | Low address bits of the load |
| ld_size | input | 2 | Load size code |
| ld_unsigned | input | 1 | 1 = zero-extend, 0 = sign-extend |
| ld_result | output | 64 | Registered aligned and extended load value |

## Verification
The access path is swept over every size at every lane offset. This separates aligned strobes from the misaligned case and shows whether the replicated data depends on the size alone. Negative offsets and a base close to 2^64 show whether the offset is sign-extended and whether the sum wraps. The return path is driven with two words: one with the top bit of every byte set and one with it clear. Across each size, lane and signedness, this tells sign extension apart from zero extension, and it exposes a wrong lane pick or wrong fill bytes past lane 7. Pseudo-random vectors then cover the remaining mixes against a behavioural model that is compared on every clock.

// File: rtl/lane_align_pkg.sv
package lane_align_pkg;

    localparam int XLEN   = 64;
    localparam int LANES  = XLEN / 8;
    localparam int LANE_W = $clog2(LANES);

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } acc_size_e;

    // Registered access-side result
    typedef struct packed {
        logic [XLEN-1:0]  eff;
        logic [XLEN-1:0]  line;
        logic [LANES-1:0] strobe;
        logic [XLEN-1:0]  wdata;
        logic             misal;
    } st_beat_t;

    // Number of bytes touched by a size code
    function automatic int size_bytes(input logic [1:0] sz);
        return 1 << sz;
    endfunction

    // Low-bit mask that must be clear for natural alignment
    function automatic logic [LANE_W-1:0] lane_mask(input logic [1:0] sz);
        return LANE_W'(size_bytes(sz) - 1);
    endfunction

    // Keep the low bytes named by sz and fill the rest with zero or the sign bit
    function automatic logic [XLEN-1:0] extend_lanes(
        input logic [XLEN-1:0] v,
        input logic [1:0]      sz,
        input logic            uns
    );
        logic [XLEN-1:0] r;
        logic            fill;
        int              top;
        top = size_bytes(sz) * 8;
        case (acc_size_e'(sz))
            SZ_BYTE: fill = v[7];
            SZ_HALF: fill = v[15];
            SZ_WORD: fill = v[31];
            default: fill = v[XLEN-1];
        endcase
        if (uns) fill = 1'b0;
        for (int i = 0; i < XLEN; i++) begin
            r[i] = (i < top) ? v[i] : fill;
        end
        return r;
    endfunction

endpackage

// File: rtl/lane_addr_gen.sv
module lane_addr_gen
    import lane_align_pkg::*;
#(
    parameter int IMM_W = 12
) (
    input  logic [XLEN-1:0]   base,
    input  logic [IMM_W-1:0]  offset,
    input  logic [1:0]        size,
    output logic [XLEN-1:0]   eff,
    output logic [XLEN-1:0]   line,
    output logic [LANE_W-1:0] lane,
    output logic              misal
);

    localparam int EXT_W = XLEN - IMM_W;

    logic [XLEN-1:0] off_ext;

    assign off_ext = {{EXT_W{offset[IMM_W-1]}}, offset};
    assign eff     = base + off_ext;
    assign lane    = eff[LANE_W-1:0];
    assign line    = {eff[XLEN-1:LANE_W], {LANE_W{1'b0}}};
    assign misal   = (lane & lane_mask(size)) != '0;

endmodule

// File: rtl/lane_store_steer.sv
module lane_store_steer
    import lane_align_pkg::*;
(
    input  logic [XLEN-1:0]   data,
    input  logic [1:0]        size,
    input  logic [LANE_W-1:0] lane,
    input  logic              misal,
    output logic [LANES-1:0]  strobe,
    output logic [XLEN-1:0]   wdata
);

    logic [LANE_W-1:0] rep_mask;
    logic [LANE_W:0]   span;
    logic [LANE_W:0]   first;
    logic [LANE_W:0]   limit;

    assign rep_mask = lane_mask(size);
    assign span     = (LANE_W + 1)'(size_bytes(size));
    assign first    = {1'b0, lane};
    assign limit    = first + span;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [LANE_W:0] POS = (LANE_W + 1)'(g);
        logic [LANE_W-1:0] src;

        // lane g repeats source byte (g mod n)
        assign src = LANE_W'(g) & rep_mask;
        assign wdata[g*8 +: 8] = data[src*8 +: 8];

        assign strobe[g] = !misal && (first <= POS) && (POS < limit);
    end

endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
    import lane_align_pkg::*;
(
    input  logic [XLEN-1:0]   word,
    input  logic [LANE_W-1:0] lane,
    input  logic [1:0]        size,
    input  logic              uns,
    output logic [XLEN-1:0]   result
);

    logic [XLEN-1:0] shifted;

    for (genvar g = 0; g < LANES; g++) begin : g_pick
        logic [LANE_W:0] src;
        assign src = {1'b0, lane} + (LANE_W + 1)'(g);
        assign shifted[g*8 +: 8] = src[LANE_W] ? 8'h00
                                               : word[src[LANE_W-1:0]*8 +: 8];
    end

    assign result = extend_lanes(shifted, size, uns);

endmodule

// File: rtl/mem_lane_align.sv
module mem_lane_align
    import lane_align_pkg::*;
#(
    parameter int IMM_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [XLEN-1:0]   acc_base,
    input  logic [IMM_W-1:0]  acc_offset,
    input  logic [1:0]        acc_size,
    input  logic [XLEN-1:0]   acc_wdata,
    output logic [XLEN-1:0]   eff_addr,
    output logic [XLEN-1:0]   line_addr,
    output logic [LANES-1:0]  byte_en,
    output logic [XLEN-1:0]   wr_data,
    output logic              misaligned,
    input  logic [XLEN-1:0]   ld_word,
    input  logic [LANE_W-1:0] ld_lane,
    input  logic [1:0]        ld_size,
    input  logic              ld_unsigned,
    output logic [XLEN-1:0]   ld_result
);

    st_beat_t          st_d, st_q;
    logic [LANE_W-1:0] acc_lane;
    logic [XLEN-1:0]   ld_d, ld_q;

    lane_addr_gen #(.IMM_W(IMM_W)) u_addr (
        .base   (acc_base),
        .offset (acc_offset),
        .size   (acc_size),
        .eff    (st_d.eff),
        .line   (st_d.line),
        .lane   (acc_lane),
        .misal  (st_d.misal)
    );

    lane_store_steer u_steer (
        .data   (acc_wdata),
        .size   (acc_size),
        .lane   (acc_lane),
        .misal  (st_d.misal),
        .strobe (st_d.strobe),
        .wdata  (st_d.wdata)
    );

    lane_load_extract u_extract (
        .word   (ld_word),
        .lane   (ld_lane),
        .size   (ld_size),
        .uns    (ld_unsigned),
        .result (ld_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
            ld_q <= '0;
        end else begin
            st_q <= st_d;
            ld_q <= ld_d;
        end
    end

    assign eff_addr   = st_q.eff;
    assign line_addr  = st_q.line;
    assign byte_en    = st_q.strobe;
    assign wr_data    = st_q.wdata;
    assign misaligned = st_q.misal;
    assign ld_result  = ld_q;

endmodule

// File: rtl/lane_align_chk.sv
module lane_align_chk #(
    parameter int IMM_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic [63:0]       acc_base,
    input logic [IMM_W-1:0]  acc_offset,
    input logic [1:0]        acc_size,
    input logic [63:0]       eff_addr,
    input logic [63:0]       line_addr,
    input logic [7:0]        byte_en,
    input logic [63:0]       wr_data,
    input logic              misaligned,
    input logic [63:0]       ld_word,
    input logic [2:0]        ld_lane,
    input logic [1:0]        ld_size,
    input logic              ld_unsigned,
    input logic [63:0]       ld_result
);

    logic primed;

    always_ff @(posedge clk) begin
        if (rst) primed <= 1'b0;
        else     primed <= 1'b1;
    end

    // R1
    eff_sum_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        eff_addr == $past(acc_base)
                    + {{(64-IMM_W){$past(acc_offset[IMM_W-1])}}, $past(acc_offset)});

    // R2
    line_addr_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        line_addr == {eff_addr[63:3], 3'b000});

    // R3
    misal_quiet_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        misaligned |-> byte_en == 8'h00);

    // R4
    strobe_count_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        !misaligned |-> $countones(byte_en) == (1 << $past(acc_size)));

    // R8
    ld_zero_byte_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(ld_unsigned) && $past(ld_size) == 2'd0) |-> ld_result[63:8] == 56'd0);

    // R9
    ld_double_chk: assert property (@(posedge clk) disable iff (rst || !primed)
        ($past(ld_size) == 2'd3 && $past(ld_lane) == 3'd0) |-> ld_result == $past(ld_word));

    // R10
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (eff_addr == 64'd0 && line_addr == 64'd0 && byte_en == 8'd0
                 && wr_data == 64'd0 && !misaligned && ld_result == 64'd0));

endmodule

bind mem_lane_align lane_align_chk #(.IMM_W(IMM_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .acc_base    (acc_base),
    .acc_offset  (acc_offset),
    .acc_size    (acc_size),
    .eff_addr    (eff_addr),
    .line_addr   (line_addr),
    .byte_en     (byte_en),
    .wr_data     (wr_data),
    .misaligned  (misaligned),
    .ld_word     (ld_word),
    .ld_lane     (ld_lane),
    .ld_size     (ld_size),
    .ld_unsigned (ld_unsigned),
    .ld_result   (ld_result)
);

// File: tb/mem_lane_align_bench.sv
module mem_lane_align_bench;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [63:0] acc_base = '0;
    logic [11:0] acc_offset = '0;
    logic [1:0]  acc_size = '0;
    logic [63:0] acc_wdata = '0;
    logic [63:0] eff_addr, line_addr, wr_data, ld_result;
    logic [7:0]  byte_en;
    logic        misaligned;
    logic [63:0] ld_word = '0;
    logic [2:0]  ld_lane = '0;
    logic [1:0]  ld_size = '0;
    logic        ld_unsigned = 1'b0;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mem_lane_align u_mem_lane_align (
        .clk(clk), .rst(rst),
        .acc_base(acc_base), .acc_offset(acc_offset), .acc_size(acc_size),
        .acc_wdata(acc_wdata), .eff_addr(eff_addr), .line_addr(line_addr),
        .byte_en(byte_en), .wr_data(wr_data), .misaligned(misaligned),
        .ld_word(ld_word), .ld_lane(ld_lane), .ld_size(ld_size),
        .ld_unsigned(ld_unsigned), .ld_result(ld_result)
    );

    task automatic check64(input string req, input string what,
                           input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Behavioural reference values for the inputs currently driven
    logic [63:0] m_eff, m_line, m_wd, m_ld;
    logic [7:0]  m_be;
    logic        m_mis;

    task automatic model();
        int n, lo, ln, top;
        logic [63:0] sh;
        logic sign;
        m_eff  = acc_base + 64'($signed(acc_offset));
        m_line = m_eff & ~64'd7;
        n  = 1 << acc_size;
        lo = int'(m_eff[2:0]);
        m_mis = (lo % n) != 0;
        for (int i = 0; i < 8; i++) begin
            m_be[i] = !m_mis && i >= lo && i < lo + n;
            m_wd[8*i +: 8] = acc_wdata[8*(i % n) +: 8];
        end
        ln  = int'(ld_lane);
        sh  = ld_word >> (8 * ln);
        top = 8 * (1 << ld_size);
        sign = (top < 64) ? sh[top-1] : 1'b0;
        for (int b = 0; b < 64; b++) begin
            if (b < top) m_ld[b] = sh[b];
            else         m_ld[b] = ld_unsigned ? 1'b0 : sign;
        end
    endtask

    // Drive one vector at a falling edge, compare one clock later
    task automatic step(input logic [63:0] b, input logic [11:0] off,
                        input logic [1:0] sz, input logic [63:0] d,
                        input logic [63:0] w, input logic [2:0] ln,
                        input logic [1:0] lsz, input logic uns);
        @(negedge clk);
        acc_base = b; acc_offset = off; acc_size = sz; acc_wdata = d;
        ld_word = w; ld_lane = ln; ld_size = lsz; ld_unsigned = uns;
        model();
        @(negedge clk);
        check64("R1", "eff_addr", eff_addr, m_eff);
        check64("R2", "line_addr", line_addr, m_line);
        check64("R3", "misaligned", {63'd0, misaligned}, {63'd0, m_mis});
        check64("R4", "byte_en", {56'd0, byte_en}, {56'd0, m_be});
        check64("R5", "wr_data", wr_data, m_wd);
        if (lsz == 2'd3 && ln == 3'd0)
            check64("R9", "ld_result", ld_result, m_ld);
        else if (uns)
            check64("R8", "ld_result", ld_result, m_ld);
        else
            check64("R7", "ld_result", ld_result, m_ld);
    endtask

    localparam logic [63:0] NEG_W = 64'hF1E2D3C4B5A69788;
    localparam logic [63:0] POS_W = 64'h7172737475767778;
    localparam logic [63:0] SRC_D = 64'h0123456789ABCDEF;

    initial begin
        // R10: outputs stay clear under reset while inputs are busy
        acc_base = 64'hDEAD_BEEF_0000_1234; acc_offset = 12'h7FF; acc_wdata = '1;
        ld_word = '1; ld_size = 2'd0;
        repeat (3) @(negedge clk);
        check64("R10", "eff_addr", eff_addr, 64'd0);
        check64("R10", "byte_en", {56'd0, byte_en}, 64'd0);
        check64("R10", "wr_data", wr_data, 64'd0);
        check64("R10", "ld_result", ld_result, 64'd0);
        rst = 1'b0;

        // R1: negative offset, and a sum that wraps past 2^64
        step(64'h1000, 12'hFFF, 2'd0, SRC_D, NEG_W, 3'd0, 2'd0, 1'b0);
        step(64'hFFFF_FFFF_FFFF_FFFC, 12'h008, 2'd2, SRC_D, POS_W, 3'd0, 2'd3, 1'b1);
        step(64'h8000, 12'h800, 2'd3, SRC_D, NEG_W, 3'd0, 2'd3, 1'b0);

        // R3 R4 R5: every size at every lane
        for (int sz = 0; sz < 4; sz++) begin
            for (int ln = 0; ln < 8; ln++) begin
                step(64'h2000, 12'(ln), 2'(sz), SRC_D, POS_W, 3'(ln), 2'(sz), 1'b0);
            end
        end

        // R6 R7 R8 R9: every load shape on both words
        for (int uns = 0; uns < 2; uns++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int ln = 0; ln < 8; ln++) begin
                    step(64'h40, 12'h0, 2'd3, 64'hFFFF_0000_AAAA_5555,
                         NEG_W, 3'(ln), 2'(sz), 1'(uns));
                    step(64'h40, 12'h0, 2'd0, 64'h11,
                         POS_W, 3'(ln), 2'(sz), 1'(uns));
                end
            end
        end

        // Mixed pseudo-random vectors
        for (int k = 0; k < 400; k++) begin
            step({$urandom, $urandom}, 12'($urandom), 2'($urandom),
                 {$urandom, $urandom}, {$urandom, $urandom},
                 3'($urandom), 2'($urandom), 1'($urandom));
        end

        // R10: reset asserted mid-stream clears the registered outputs
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check64("R10", "misaligned", {63'd0, misaligned}, 64'd0);
        check64("R10", "line_addr", line_addr, 64'd0);
        rst = 1'b0;

        done = 1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            fails++;
            $display("FAIL watchdog: run did not complete");
            done = 1;
        end
    end

    initial begin
        wait (done);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule